// File: doc/BRIEF.md
# Integer ALU with Bit-Counting and Random Output

This is the execute-stage arithmetic and logic unit of a small RISC core. Each cycle it takes operand A, a second operand and an operation code, and it returns a 32-bit result and a carry flag in the same cycle. The second operand is either a register value or a zero-extended 16-bit immediate. The unit adds, subtracts, shifts, rotates and, when a parameter enables it, multiplies. It also counts set bits, clear bits and bit-to-bit transitions in operand A, and it supplies pseudo-random words.

Operations fall into two groups. In the arithmetic group a 4-bit code selects the function. In the logic group a 2-bit code selects OR, AND, XOR or NOT. The random source is the only state in the block. It is a 32-bit LFSR, and it moves forward only when a random operation is actually issued.

Top module: `bitcount_alu`

## Requirements
- R1: Arithmetic code 0 (add) returns the low 32 bits of A plus B, with carry equal to the carry out of bit 31.
- R2: Arithmetic code 1 (subtract) returns A minus B modulo 2^32, with carry set exactly when A is less than B as unsigned numbers (borrow).
- R3: With `useImm` high, operand B is the 16-bit `imm` zero-extended and `regB` is ignored; with `useImm` low, operand B is `regB`.
- R4: Codes 2 and 3 are logical shift right and logical shift left of A by the low 5 bits of B.
- R5: Codes 4 and 5 rotate A right and left by the low 5 bits of B; an amount of 0 returns A unchanged.
- R6: Code 6 returns the number of one bits in A (0 to 32).
- R7: Code 7 returns the number of zero bits in A (0 to 32).
- R8: Code 8 returns the number of positions i in 0..30 where bit i of A differs from bit i+1 (0 to 31).
- R9: Code 9 returns the current LFSR state. On a rising clock edge with `issue` high and code 9 selected in the arithmetic group, the state is replaced by (state >> 1) XOR (bit 0 of state ? 32'h80200003 : 0). Otherwise it holds, and it is never zero.
- R10: Code 10 returns the low 32 bits of A times B when multiply is enabled (the default); with multiply disabled it returns 0.
- R11: With `isLogic` high, `logicOp` 0 gives A OR B, 1 gives A AND B, 2 gives A XOR B and 3 gives NOT A, which ignores B.
- R12: Carry is 0 for every operation other than add and subtract. Arithmetic codes 11 to 15 return 0.
- R13: While reset (`rstN` low) is asserted and after it is released, the LFSR state is 32'h00000001 until the first issued random operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the random-source register |
| rstN | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | The presented operation is executed this cycle |
| isLogic | input | 1 | 1 selects the logic group, 0 the arithmetic group |
| aluOp | input | 4 | Arithmetic operation code |
| logicOp | input | 2 | Logic operation code |
| useImm | input | 1 | Take operand B from the immediate |
| opA | input | 32 | Operand A |
| regB | input | 32 | Register form of operand B |
| imm | input | 16 | Immediate form of operand B |
| result | output | 32 | Operation result |
| carry | output | 1 | Carry out of add, borrow of subtract |

## Verification
Every result and carry value follows from the inputs in the same cycle. The bench drives on the falling edge and samples a short settle time later, before the next rising edge. The random state is the exception: an issued random operation changes what code 9 shows only after the following rising edge. The bench's own LFSR model therefore advances after that edge, and the next vector compares against the advanced value. Presenting code 9 without `issue` checks that the value holds.

// File: rtl/bitcount_alu_pkg.sv
package bitcount_alu_pkg;

  localparam int OP_W  = 4;
  localparam int LOP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_SHR   = 4'd2,
    OP_SHL   = 4'd3,
    OP_ROR   = 4'd4,
    OP_ROL   = 4'd5,
    OP_ONES  = 4'd6,
    OP_ZEROS = 4'd7,
    OP_CHG   = 4'd8,
    OP_RAND  = 4'd9,
    OP_MUL   = 4'd10
  } arithOp_e;

  typedef enum logic [LOP_W-1:0] {
    LOP_OR  = 2'd0,
    LOP_AND = 2'd1,
    LOP_XOR = 2'd2,
    LOP_NOT = 2'd3
  } logicOp_e;

  // One-hot result selects plus side controls, control -> datapath
  typedef struct packed {
    logic doAdd;
    logic doSub;
    logic doShr;
    logic doShl;
    logic doRor;
    logic doRol;
    logic doOnes;
    logic doZeros;
    logic doChg;
    logic doRand;
    logic doMul;
    logic doOr;
    logic doAnd;
    logic doXor;
    logic doNot;
    logic useImm;
    logic stepRng;
  } aluStrobes_t;

endpackage

// File: rtl/bitcount_alu_ctrl.sv
module bitcount_alu_ctrl
  import bitcount_alu_pkg::*;
#(
  parameter bit MUL_EN = 1'b1
) (
  input  logic             issue,
  input  logic             isLogic,
  input  logic [OP_W-1:0]  aluOp,
  input  logic [LOP_W-1:0] logicOp,
  input  logic             useImm,
  output aluStrobes_t      strb
);

  always_comb begin
    strb        = '0;
    strb.useImm = useImm;
    if (isLogic) begin
      case (logicOp)
        LOP_OR:  strb.doOr  = 1'b1;
        LOP_AND: strb.doAnd = 1'b1;
        LOP_XOR: strb.doXor = 1'b1;
        default: strb.doNot = 1'b1;
      endcase
    end else begin
      case (aluOp)
        OP_ADD:   strb.doAdd   = 1'b1;
        OP_SUB:   strb.doSub   = 1'b1;
        OP_SHR:   strb.doShr   = 1'b1;
        OP_SHL:   strb.doShl   = 1'b1;
        OP_ROR:   strb.doRor   = 1'b1;
        OP_ROL:   strb.doRol   = 1'b1;
        OP_ONES:  strb.doOnes  = 1'b1;
        OP_ZEROS: strb.doZeros = 1'b1;
        OP_CHG:   strb.doChg   = 1'b1;
        OP_RAND: begin
          strb.doRand  = 1'b1;
          strb.stepRng = issue;
        end
        OP_MUL:   strb.doMul   = MUL_EN;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/bitcount_alu_rng.sv
module bitcount_alu_rng #(
  parameter int           W    = 32,
  parameter logic [W-1:0] TAPS = 32'h80200003,
  parameter logic [W-1:0] SEED = 32'h00000001
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         step,
  output logic [W-1:0] state
);

  logic [W-1:0] nextState;

  // Galois form: shift toward bit 0, fold the tap mask in when bit 0 leaves
  always_comb begin
    nextState = state >> 1;
    if (state[0]) nextState = nextState ^ TAPS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     state <= SEED;
    else if (step) state <= nextState;
  end

endmodule

// File: rtl/bitcount_alu_dp.sv
module bitcount_alu_dp
  import bitcount_alu_pkg::*;
#(
  parameter int W      = 32,
  parameter int IMM_W  = 16,
  parameter bit MUL_EN = 1'b1
) (
  input  aluStrobes_t      strb,
  input  logic [W-1:0]     opA,
  input  logic [W-1:0]     regB,
  input  logic [IMM_W-1:0] imm,
  input  logic [W-1:0]     rngVal,
  output logic [W-1:0]     result,
  output logic             carry
);

  localparam int SHW   = $clog2(W);
  localparam int CNT_W = $clog2(W + 1);

  function automatic logic [CNT_W-1:0] popCount(input logic [W-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++) acc = acc + CNT_W'(v[i]);
    return acc;
  endfunction

  logic [W-1:0]     bEff;
  logic [W:0]       addFull, subFull;
  logic [SHW-1:0]   shAmt;
  logic [2*W-1:0]   dblA, rorWide, rolWide;
  logic [W-1:0]     edgeBits;
  logic [CNT_W-1:0] onesCnt, zerosCnt, chgCnt;
  logic [W-1:0]     mulRes;

  assign bEff    = strb.useImm ? {{(W-IMM_W){1'b0}}, imm} : regB;
  assign addFull = {1'b0, opA} + {1'b0, bEff};
  assign subFull = {1'b0, opA} - {1'b0, bEff};
  assign shAmt   = bEff[SHW-1:0];
  assign dblA    = {opA, opA};
  assign rorWide = dblA >> shAmt;
  assign rolWide = dblA << shAmt;

  // neighbour differences, top position masked out (it has no upper neighbour)
  assign edgeBits = (opA ^ (opA >> 1)) & {1'b0, {(W-1){1'b1}}};
  assign onesCnt  = popCount(opA);
  assign zerosCnt = CNT_W'(W) - onesCnt;
  assign chgCnt   = popCount(edgeBits);

  generate
    if (MUL_EN) begin : g_mul
      assign mulRes = opA * bEff;
    end else begin : g_nomul
      assign mulRes = '0;
    end
  endgenerate

  // one-hot AND-OR result mux
  always_comb begin
    result = ({W{strb.doAdd}}   & addFull[W-1:0])
           | ({W{strb.doSub}}   & subFull[W-1:0])
           | ({W{strb.doShr}}   & (opA >> shAmt))
           | ({W{strb.doShl}}   & (opA << shAmt))
           | ({W{strb.doRor}}   & rorWide[W-1:0])
           | ({W{strb.doRol}}   & rolWide[2*W-1:W])
           | ({W{strb.doOnes}}  & {{(W-CNT_W){1'b0}}, onesCnt})
           | ({W{strb.doZeros}} & {{(W-CNT_W){1'b0}}, zerosCnt})
           | ({W{strb.doChg}}   & {{(W-CNT_W){1'b0}}, chgCnt})
           | ({W{strb.doRand}}  & rngVal)
           | ({W{strb.doMul}}   & mulRes)
           | ({W{strb.doOr}}    & (opA | bEff))
           | ({W{strb.doAnd}}   & (opA & bEff))
           | ({W{strb.doXor}}   & (opA ^ bEff))
           | ({W{strb.doNot}}   & ~opA);
    carry  = (strb.doAdd & addFull[W]) | (strb.doSub & subFull[W]);
  end

endmodule

// File: rtl/bitcount_alu.sv
module bitcount_alu
  import bitcount_alu_pkg::*;
#(
  parameter int W      = 32,
  parameter int IMM_W  = 16,
  parameter bit MUL_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issue,
  input  logic             isLogic,
  input  logic [OP_W-1:0]  aluOp,
  input  logic [LOP_W-1:0] logicOp,
  input  logic             useImm,
  input  logic [W-1:0]     opA,
  input  logic [W-1:0]     regB,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     result,
  output logic             carry
);

  aluStrobes_t  strb;
  logic [W-1:0] rngState;

  bitcount_alu_ctrl #(.MUL_EN(MUL_EN)) ctrl_i (
    .issue   (issue),
    .isLogic (isLogic),
    .aluOp   (aluOp),
    .logicOp (logicOp),
    .useImm  (useImm),
    .strb    (strb)
  );

  bitcount_alu_rng #(.W(W)) rng_i (
    .clk   (clk),
    .rstN  (rstN),
    .step  (strb.stepRng),
    .state (rngState)
  );

  bitcount_alu_dp #(.W(W), .IMM_W(IMM_W), .MUL_EN(MUL_EN)) dp_i (
    .strb   (strb),
    .opA    (opA),
    .regB   (regB),
    .imm    (imm),
    .rngVal (rngState),
    .result (result),
    .carry  (carry)
  );

endmodule

// File: rtl/bitcount_alu_chk.sv
module bitcount_alu_chk #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             issue,
  input logic             isLogic,
  input logic [3:0]       aluOp,
  input logic             useImm,
  input logic [W-1:0]     opA,
  input logic [W-1:0]     regB,
  input logic [IMM_W-1:0] imm,
  input logic [W-1:0]     result,
  input logic             carry,
  input logic [W-1:0]     rngState
);

  logic [W-1:0] bSeen;
  logic         randIssued;
  assign bSeen      = useImm ? W'(imm) : regB;
  assign randIssued = issue && !isLogic && (aluOp == 4'd9);

  p_carry_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    (isLogic || (aluOp > 4'd1)) |-> !carry);

  p_borrow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!isLogic && aluOp == 4'd1) |-> (carry == (opA < bSeen)));

  p_count_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!isLogic && (aluOp == 4'd6 || aluOp == 4'd7 || aluOp == 4'd8)) |-> (result <= W));

  p_rng_nonzero_r9: assert property (@(posedge clk) disable iff (!rstN)
    rngState != '0);

  p_rng_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !randIssued |=> $stable(rngState));

  p_rng_moves_r9: assert property (@(posedge clk) disable iff (!rstN)
    randIssued |=> (rngState != $past(rngState)));

endmodule

bind bitcount_alu bitcount_alu_chk #(.W(W), .IMM_W(IMM_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .issue    (issue),
  .isLogic  (isLogic),
  .aluOp    (aluOp),
  .useImm   (useImm),
  .opA      (opA),
  .regB     (regB),
  .imm      (imm),
  .result   (result),
  .carry    (carry),
  .rngState (rngState)
);

// File: tb/bitcount_alu_tb_top.sv
module bitcount_alu_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issue = 1'b0;
  logic        isLogic = 1'b0;
  logic [3:0]  aluOp = '0;
  logic [1:0]  logicOp = '0;
  logic        useImm = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] regB = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic        carry;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [31:0] modelRng = 32'h00000001;

  always #4 clk = ~clk;

  bitcount_alu dut_i (
    .clk(clk), .rstN(rstN), .issue(issue), .isLogic(isLogic), .aluOp(aluOp),
    .logicOp(logicOp), .useImm(useImm), .opA(opA), .regB(regB), .imm(imm),
    .result(result), .carry(carry)
  );

  function automatic int countOnes(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic logic [31:0] rngNext(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'h80200003) : (s >> 1);
  endfunction

  function automatic logic [32:0] expected(input logic il, input logic [3:0] op,
      input logic [1:0] lop, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] rng);
    logic [32:0] w;
    int s;
    int t;
    s = int'(b[4:0]);
    if (il) begin
      case (lop)
        2'd0: return {1'b0, a | b};
        2'd1: return {1'b0, a & b};
        2'd2: return {1'b0, a ^ b};
        default: return {1'b0, ~a};
      endcase
    end
    case (op)
      4'd0: begin w = {1'b0, a} + {1'b0, b}; return w; end
      4'd1: return {a < b, a - b};
      4'd2: return {1'b0, a >> s};
      4'd3: return {1'b0, a << s};
      4'd4: return {1'b0, (s == 0) ? a : ((a >> s) | (a << (32 - s)))};
      4'd5: return {1'b0, (s == 0) ? a : ((a << s) | (a >> (32 - s)))};
      4'd6: return {1'b0, 32'(countOnes(a))};
      4'd7: return {1'b0, 32'(32 - countOnes(a))};
      4'd8: begin
        t = 0;
        for (int i = 0; i < 31; i++) if (a[i] != a[i+1]) t++;
        return {1'b0, 32'(t)};
      end
      4'd9: return {1'b0, rng};
      4'd10: return {1'b0, a * b};
      default: return 33'd0;
    endcase
  endfunction

  task automatic apply(input string req, input logic iss, input logic il,
      input logic [3:0] op, input logic [1:0] lop, input logic ui,
      input logic [31:0] a, input logic [31:0] rb, input logic [15:0] im);
    logic [32:0] exp;
    @(negedge clk);
    issue = iss; isLogic = il; aluOp = op; logicOp = lop; useImm = ui;
    opA = a; regB = rb; imm = im;
    #1;
    exp = expected(il, op, lop, a, ui ? {16'h0, im} : rb, modelRng);
    compared++;
    if ({carry, result} !== exp) begin
      mismatched++;
      $display("FAIL %s: op=%0d logic=%0b a=%h -> got carry=%b result=%h, expected carry=%b result=%h",
               req, op, il, a, carry, result, exp[32], exp[31:0]);
    end
    if (iss && !il && op == 4'd9) modelRng = rngNext(modelRng);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R13: reset value visible while reset is held
    aluOp = 4'd9;
    #20;
    compared++;
    if (result !== 32'h00000001) begin
      mismatched++;
      $display("FAIL R13: got %h expected 00000001", result);
    end
    @(negedge clk); rstN = 1'b1;
    apply("R13", 0, 0, 4'd9, 0, 0, 32'h0, 32'h0, 16'h0);

    apply("R1", 1, 0, 4'd0, 0, 0, 32'hFFFFFFFF, 32'h1, 16'h0);
    apply("R1", 1, 0, 4'd0, 0, 0, 32'h12345678, 32'h11111111, 16'h0);
    apply("R2", 1, 0, 4'd1, 0, 0, 32'h0, 32'h1, 16'h0);
    apply("R2", 1, 0, 4'd1, 0, 0, 32'h55, 32'h55, 16'h0);
    apply("R3", 1, 0, 4'd0, 0, 1, 32'h0000FFFF, 32'hDEADBEEF, 16'hFFFF);
    apply("R3", 1, 1, 4'd0, 2'd0, 1, 32'h0, 32'hFFFFFFFF, 16'h8001);
    apply("R4", 1, 0, 4'd2, 0, 0, 32'h80000000, 32'd33, 16'h0);
    apply("R4", 1, 0, 4'd3, 0, 0, 32'h00000001, 32'd31, 16'h0);
    apply("R5", 1, 0, 4'd4, 0, 0, 32'h00000001, 32'd1, 16'h0);
    apply("R5", 1, 0, 4'd5, 0, 0, 32'hA5A5A5A5, 32'd32, 16'h0);
    apply("R6", 1, 0, 4'd6, 0, 0, 32'hFFFFFFFF, 32'h0, 16'h0);
    apply("R6", 1, 0, 4'd6, 0, 0, 32'h0, 32'h0, 16'h0);
    apply("R7", 1, 0, 4'd7, 0, 0, 32'h0, 32'h0, 16'h0);
    apply("R7", 1, 0, 4'd7, 0, 0, 32'hF0000001, 32'h0, 16'h0);
    apply("R8", 1, 0, 4'd8, 0, 0, 32'hAAAAAAAA, 32'h0, 16'h0);
    apply("R8", 1, 0, 4'd8, 0, 0, 32'h80000000, 32'h0, 16'h0);
    apply("R8", 1, 0, 4'd8, 0, 0, 32'h00000001, 32'h0, 16'h0);
    apply("R9", 0, 0, 4'd9, 0, 0, 32'h0, 32'h0, 16'h0);
    apply("R9", 1, 0, 4'd9, 0, 0, 32'h0, 32'h0, 16'h0);
    apply("R9", 1, 0, 4'd9, 0, 0, 32'h0, 32'h0, 16'h0);
    apply("R9", 0, 0, 4'd9, 0, 0, 32'h0, 32'h0, 16'h0);
    apply("R9", 1, 1, 4'd9, 2'd1, 0, 32'hFF, 32'h0F, 16'h0);
    apply("R9", 0, 0, 4'd9, 0, 0, 32'h0, 32'h0, 16'h0);
    apply("R10", 1, 0, 4'd10, 0, 0, 32'h00010001, 32'h00010001, 16'h0);
    apply("R11", 1, 1, 4'd0, 2'd3, 0, 32'h0F0F0F0F, 32'h12345678, 16'h0);
    apply("R11", 1, 1, 4'd0, 2'd3, 0, 32'h0F0F0F0F, 32'hFFFFFFFF, 16'h0);
    apply("R11", 1, 1, 4'd0, 2'd2, 0, 32'h0F0F0F0F, 32'hFF00FF00, 16'h0);
    apply("R12", 1, 0, 4'd15, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0);
    apply("R12", 1, 0, 4'd11, 0, 0, 32'h1, 32'h1, 16'h0);

    for (int n = 0; n < 600; n++) begin
      logic        il;
      logic [3:0]  op;
      il = ($urandom % 4) == 0;
      op = 4'($urandom % 16);
      apply(il ? "R11" : "R1/R12 random", 1'($urandom), il, op, 2'($urandom),
            1'($urandom), $urandom, $urandom, 16'($urandom));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule